// File: doc/BRIEF.md
# Power-Management Companion Serial Bridge

This block sits between a simple processor bus and a three-wire serial link to a power-management companion chip. A processor store into a 4 KB window at bus offset 0x8000 becomes a companion register write. The bridge holds it in a small write FIFO and later shifts it out as one serial frame. A read takes a single store of the target address into a read-command register. The bridge then runs the serial read by itself. Software polls a read-result register until its busy flag clears. It then checks the echoed address field against the low 12 bits of the address it asked for before it uses the data.

A serial frame is 29 bits long, sent most significant bit first. It holds a direction bit (1 = read, 0 = write), a 12-bit companion address and a 16-bit data field. The bridge drives each bit while the serial clock is low, and both ends sample on the rising edge. In a read frame the companion returns the 16 data bits on the input line during the last 16 clock periods. A configuration bit chooses between a serial clock that runs all the time and one that is gated off whenever no frame is in flight. A block of channel-enable bits is also held here for a neighbouring arbiter: channels 0 and 1 are software channels, and channels 2 to 49 are hardware channels.

Top module: `pmic_bridge`

## Requirements
- R1: A bus store to address 0x8000 + a (a in 0..0xFFF) produces one serial frame {0, a[11:0], wdata[15:0]}, sent MSB first. Each bit is valid on sdo_o at the rising edge of sclk_o, and cs_o stays high for exactly the 29 bits of the frame.
- R2: A store to the read-command register (offset 0x08) starts a read with no further action. Bit 31 of the read-result register (offset 0x0C) reads 1 from the cycle after that store and returns to 0 once the read frame has ended.
- R3: After a read, the read-result register holds the 16 bits taken from sdi_i in bits 15:0. Bits 27:16 hold wdata[11:0] of the command, and bits 30:28 read 0. A read frame is {1, a[11:0], 16 zero bits} on sdo_o.
- R4: The FIFO status register (offset 0x10) shows FIFO full in bit 11 and FIFO empty in bit 10. After reset it reads empty and not full.
- R5: When a window store finds the write FIFO full, ready_o is held low until an entry frees. The store is then taken, and no write is lost.
- R6: Writes queued before a read command are all sent before that read frame.
- R7: Bit 30 of the clock register (offset 0x04) set to 1 makes sclk_o toggle all the time. Set to 0 (the reset value), it keeps sclk_o low whenever cs_o is low. Frames are correct in both modes.
- R8: The control register (offset 0x00) resets to 0, which selects 12-bit companion addressing. Its bit 0 reads back as written.
- R9: The channel-enable register at offset 0x14 holds channels 0 to 31 in bits 31:0, with bits 1:0 (the software channels) always reading 0. The register at offset 0x18 holds channels 32 to 49 in bits 17:0, with the upper bits reading 0.
- R10: A store to the read-command register while a read is busy is ignored. It sends no frame and does not change the later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 16 | Byte address relative to bridge base |
| wdata_i | input | 32 | Store data |
| ready_o | output | 1 | Access completes this cycle; low = wait state |
| rdata_o | output | 32 | Load data, valid in the access cycle |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | 1 | Frame active |
| sdo_o | output | 1 | Serial data to companion |
| sdi_i | input | 1 | Serial data from companion |

## Verification
The bench models the companion on the serial pins, and a scoreboard compares every frame with the order in which the accesses were issued. It then goes after the edge cases. It overfills the FIFO with stores: a bridge that drops stores instead of stalling would lose a frame. It queues writes right before a read command: a read that overtakes them would arrive out of order. It polls the busy flag in the very next cycle: a late flag would read 0. It sends a command with address bits set above bit 11, where an unmasked echo would fail the compare. Further cases are a second command while busy, which a wrong design would turn into an extra frame or a changed echo; the clock mode toggled around idle periods; and the two read-as-zero channel bits.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_CLKCFG = 8'h04;
  localparam logic [7:0] OFF_RDCMD  = 8'h08;
  localparam logic [7:0] OFF_RDRES  = 8'h0C;
  localparam logic [7:0] OFF_FSTS   = 8'h10;
  localparam logic [7:0] OFF_CHEN0  = 8'h14;
  localparam logic [7:0] OFF_CHEN1  = 8'h18;

  localparam logic [3:0] WIN_PAGE = 4'h8;
  localparam logic [3:0] REG_PAGE = 4'h0;

  localparam int BIT_CLK_ON = 30;
  localparam int BIT_BUSY   = 31;
  localparam int BIT_FULL   = 11;
  localparam int BIT_EMPTY  = 10;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_item_t;
endpackage

// File: rtl/pmic_wr_fifo.sv
module pmic_wr_fifo #(
  parameter int W     = 28,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wptr_q] <= din_i;
        wptr_q        <= nxt(wptr_q);
      end
      if (pop_i) rptr_q <= nxt(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R4
endmodule

// File: rtl/pmic_serial_shifter.sv
module pmic_serial_shifter #(
  parameter int FRAME_W  = 29,
  parameter int RX_W     = 16,
  parameter int HALF_DIV = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               always_on_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               is_rd_i,
  output logic               idle_o,
  output logic               done_o,
  output logic [RX_W-1:0]    rx_o,
  output logic               sclk_o,
  output logic               cs_o,
  output logic               sdo_o,
  input  logic               sdi_i
);
  localparam int CNT_W    = $clog2(FRAME_W);
  localparam int DIV_W    = $clog2(HALF_DIV + 1);
  localparam int RX_FIRST = FRAME_W - RX_W;

  logic               active_q, rd_q, ph_q, done_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   bit_q;
  logic [DIV_W-1:0]   div_q;
  logic [RX_W-1:0]    rx_q;
  logic               run, tick;

  assign run    = active_q || always_on_i;
  assign tick   = run && (div_q == DIV_W'(HALF_DIV - 1));
  assign idle_o = !active_q && !ph_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = ph_q;
  assign cs_o   = active_q;
  assign sdo_o  = active_q && sh_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      ph_q     <= 1'b0;
      done_q   <= 1'b0;
      sh_q     <= '0;
      bit_q    <= '0;
      div_q    <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && idle_o) begin
        active_q <= 1'b1;
        rd_q     <= is_rd_i;
        sh_q     <= frame_i;
        bit_q    <= '0;
        div_q    <= '0;
        ph_q     <= 1'b0;
        rx_q     <= '0;
      end else if (!run) begin
        div_q <= '0;
        ph_q  <= 1'b0;
      end else if (tick) begin
        div_q <= '0;
        ph_q  <= ~ph_q;
        if (!ph_q) begin
          // rising edge: capture companion data in the tail of a read
          if (active_q && rd_q && bit_q >= CNT_W'(RX_FIRST))
            rx_q <= {rx_q[RX_W-2:0], sdi_i};
        end else if (active_q) begin
          if (bit_q == CNT_W'(FRAME_W - 1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  AST_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> done_o); // R1
  AST_SCLK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_o && !always_on_i && $past(!always_on_i) && $past(!active_q)) |-> !sclk_o); // R7
endmodule

// File: rtl/pmic_bridge.sv
module pmic_bridge
  import pmic_bridge_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int HALF_DIV   = 2,
  parameter int NUM_CHN    = 50,
  parameter int SW_CHN     = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [15:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic        ready_o,
  output logic [31:0] rdata_o,
  output logic        sclk_o,
  output logic        cs_o,
  output logic        sdo_o,
  input  logic        sdi_i
);
  localparam int ITEM_W = ADDR_W + DATA_W;
  localparam int HI_W   = NUM_CHN - 32;
  localparam int LO_W   = 32 - SW_CHN;

  logic is_win, is_reg, wr_acc, win_wr, reg_wr, rd_cmd_wr;
  logic [7:0] off;

  logic fifo_full, fifo_empty, fifo_pop;
  wr_item_t fifo_din, fifo_dout;

  logic sh_idle, sh_done, sh_start, sh_is_rd;
  logic [FRAME_W-1:0] sh_frame;
  logic [DATA_W-1:0]  sh_rx;

  logic              ctrl_q, clk_on_q;
  logic [LO_W-1:0]   chen_lo_q;
  logic [HI_W-1:0]   chen_hi_q;
  logic              rd_busy_q, rd_pend_q, cur_rd_q;
  logic [ADDR_W-1:0] rd_addr_q, rd_echo_q;
  logic [DATA_W-1:0] rd_val_q;

  // ---------------- bus decode ----------------
  assign is_win    = (addr_i[15:12] == WIN_PAGE);
  assign is_reg    = (addr_i[15:12] == REG_PAGE) && (addr_i[11:8] == 4'h0);
  assign off       = addr_i[7:0];
  assign ready_o   = !(req_i && we_i && is_win && fifo_full);
  assign wr_acc    = req_i && we_i && ready_o;
  assign win_wr    = wr_acc && is_win;
  assign reg_wr    = wr_acc && is_reg;
  assign rd_cmd_wr = reg_wr && (off == OFF_RDCMD);

  assign fifo_din.addr = addr_i[ADDR_W-1:0];
  assign fifo_din.data = wdata_i[DATA_W-1:0];

  pmic_wr_fifo #(.W(ITEM_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (win_wr),
    .din_i   (fifo_din),
    .pop_i   (fifo_pop),
    .dout_o  (fifo_dout),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  // ---------------- frame arbitration: queued writes first ----------------
  always_comb begin
    fifo_pop = 1'b0;
    sh_start = 1'b0;
    sh_is_rd = 1'b0;
    sh_frame = {1'b1, rd_addr_q, {DATA_W{1'b0}}};
    if (sh_idle) begin
      if (!fifo_empty) begin
        fifo_pop = 1'b1;
        sh_start = 1'b1;
        sh_frame = {1'b0, fifo_dout.addr, fifo_dout.data};
      end else if (rd_pend_q) begin
        sh_start = 1'b1;
        sh_is_rd = 1'b1;
      end
    end
  end

  pmic_serial_shifter #(.FRAME_W(FRAME_W), .RX_W(DATA_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .always_on_i (clk_on_q),
    .start_i     (sh_start),
    .frame_i     (sh_frame),
    .is_rd_i     (sh_is_rd),
    .idle_o      (sh_idle),
    .done_o      (sh_done),
    .rx_o        (sh_rx),
    .sclk_o      (sclk_o),
    .cs_o        (cs_o),
    .sdo_o       (sdo_o),
    .sdi_i       (sdi_i)
  );

  // ---------------- read-command engine ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_busy_q <= 1'b0;
      rd_pend_q <= 1'b0;
      cur_rd_q  <= 1'b0;
      rd_addr_q <= '0;
      rd_echo_q <= '0;
      rd_val_q  <= '0;
    end else begin
      if (sh_start) cur_rd_q <= sh_is_rd;
      if (sh_start && sh_is_rd) rd_pend_q <= 1'b0;
      if (rd_cmd_wr && !rd_busy_q) begin
        rd_busy_q <= 1'b1;
        rd_pend_q <= 1'b1;
        rd_addr_q <= wdata_i[ADDR_W-1:0];
      end else if (sh_done && cur_rd_q) begin
        rd_busy_q <= 1'b0;
        rd_echo_q <= rd_addr_q;
        rd_val_q  <= sh_rx;
      end
    end
  end

  // ---------------- register file ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= 1'b0;
      clk_on_q  <= 1'b0;
      chen_lo_q <= '0;
      chen_hi_q <= '0;
    end else if (reg_wr) begin
      case (off)
        OFF_CTRL:   ctrl_q    <= wdata_i[0];
        OFF_CLKCFG: clk_on_q  <= wdata_i[BIT_CLK_ON];
        OFF_CHEN0:  chen_lo_q <= wdata_i[31:SW_CHN];
        OFF_CHEN1:  chen_hi_q <= wdata_i[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && is_reg) begin
      case (off)
        OFF_CTRL:   rdata_o[0] = ctrl_q;
        OFF_CLKCFG: rdata_o[BIT_CLK_ON] = clk_on_q;
        OFF_RDRES:  rdata_o = {rd_busy_q, 3'b000, rd_echo_q, rd_val_q};
        OFF_FSTS: begin
          rdata_o[BIT_FULL]  = fifo_full;
          rdata_o[BIT_EMPTY] = fifo_empty;
        end
        OFF_CHEN0:  rdata_o = {chen_lo_q, {SW_CHN{1'b0}}};
        OFF_CHEN1:  rdata_o[HI_W-1:0] = chen_hi_q;
        default: ;
      endcase
    end
  end

  AST_BUSY_ON_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd_wr && !rd_busy_q) |=> rd_busy_q); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_busy_q && !sh_done) |=> rd_busy_q); // R2
  AST_ECHO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_busy_q) |-> (rd_echo_q == rd_addr_q)); // R3
  AST_READ_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_o) && cur_rd_q) |-> fifo_empty); // R6
  AST_CMD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd_wr && rd_busy_q) |=> $stable(rd_addr_q)); // R10
endmodule

// File: tb/tb_pmic_bridge.sv
module tb_pmic_bridge;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ready_o, sclk_o, cs_o, sdo_o;
  logic [31:0] rdata_o;
  logic        sdi_i = 1'b0;

  always #4 clk = ~clk;

  pmic_bridge #(.FIFO_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o), .sclk_o(sclk_o),
    .cs_o(cs_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, frames = 0, idle_edges = 0;
  bit stall_seen = 1'b0;
  logic [28:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] reply(input logic [11:0] a);
    return {a[3:0], a} ^ 16'h3C5A;
  endfunction

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    #1;
    while (!ready_o) begin
      stall_seen = 1'b1;
      @(negedge clk); #1;
    end
    if (a[15:12] == 4'h8) exp_q.push_back({1'b0, a[11:0], d[15:0]});
    if (a == 16'h0008 && !dut_busy_model) begin
      exp_q.push_back({1'b1, d[11:0], 16'h0});
      dut_busy_model = 1'b1;
    end
    @(posedge clk); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  bit dut_busy_model = 1'b0;

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk); #1;
    req_i = 1'b0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !cs_o) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_read(output logic [31:0] d);
    d = 32'hFFFF_FFFF;
    for (int i = 0; i < 3000; i++) begin
      bus_read(16'h000C, d);
      if (!d[31]) break;
    end
    dut_busy_model = 1'b0;
  endtask

  // companion model and scoreboard monitor
  logic        prev_sclk = 1'b0, prev_cs = 1'b0, rd_frame = 1'b0;
  logic [28:0] acc = '0;
  logic [11:0] cap_addr = '0;
  int          nbits = 0;
  always @(negedge clk) begin
    if (cs_o && sclk_o && !prev_sclk) begin
      acc = {acc[27:0], sdo_o};
      nbits++;
      if (nbits == 13) begin
        rd_frame = acc[12];
        cap_addr = acc[11:0];
      end
    end
    if (cs_o && !sclk_o && prev_sclk && rd_frame && nbits >= 13 && nbits <= 28)
      sdi_i = reply(cap_addr)[28-nbits];
    if (!cs_o && sclk_o && !prev_sclk) idle_edges++;
    if (!cs_o && prev_cs) begin
      frames++;
      chk(nbits == 29, "R1 frame length", nbits, 29);
      if (exp_q.size() == 0) chk(1'b0, "R10 R1 unexpected frame", {3'b0, acc}, 32'h0);
      else begin
        logic [28:0] e;
        e = exp_q.pop_front();
        chk(acc == e, "R1 R6 frame content/order", {3'b0, acc}, {3'b0, e});
      end
      acc = '0; nbits = 0; rd_frame = 1'b0; sdi_i = 1'b0;
    end
    prev_sclk = sclk_o;
    prev_cs   = cs_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int e0, f0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // reset state
    bus_read(16'h0010, d); chk(d[10] && !d[11], "R4 reset fifo status", d, 32'h400);
    bus_read(16'h000C, d); chk(d == 0, "R2 reset read result", d, 0);
    bus_read(16'h0000, d); chk(d == 0, "R8 ctrl reset 12-bit mode", d, 0);
    chk(!cs_o && !sclk_o, "R7 idle pins after reset", {cs_o, sclk_o}, 0);

    // gated clock when idle
    e0 = idle_edges; repeat (30) @(negedge clk);
    chk(idle_edges == e0, "R7 gated sclk idle", idle_edges - e0, 0);

    // plain writes
    bus_write(16'h8123, 32'h0000_BEEF);
    bus_write(16'h8FFF, 32'hFFFF_0001);
    wait_drain();
    chk(exp_q.size() == 0, "R1 writes delivered", exp_q.size(), 0);

    // overfill FIFO
    f0 = frames;
    stall_seen = 1'b0;
    for (int i = 0; i < DEPTH + 3; i++) bus_write(16'h8000 + 16'(i * 3), 32'(16'h1000 + i));
    chk(stall_seen, "R5 stall on full", stall_seen, 1);
    bus_read(16'h0010, d); chk(d[11] && !d[10], "R4 fifo full flag", d, 32'h800);
    wait_drain();
    chk(frames - f0 == DEPTH + 3, "R5 no store lost", frames - f0, DEPTH + 3);
    bus_read(16'h0010, d); chk(d[10] && !d[11], "R4 fifo empty after drain", d, 32'h400);

    // read with high address bits set
    bus_write(16'h0008, 32'hFFFF_F7AB);
    bus_read(16'h000C, d); chk(d[31], "R2 busy next cycle", d, 32'h8000_0000);
    bus_write(16'h0008, 32'h0000_0111); // ignored while busy
    wait_read(d);
    chk(d == {4'h0, 12'h7AB, reply(12'h7AB)}, "R3 result word", d, {4'h0, 12'h7AB, reply(12'h7AB)});
    f0 = frames; repeat (200) @(negedge clk);
    chk(frames == f0 && exp_q.size() == 0, "R10 no extra frame", frames - f0, 0);
    bus_read(16'h000C, d); chk(d[27:16] == 12'h7AB, "R10 echo unchanged", d[27:16], 12'h7AB);

    // writes then read: ordering
    bus_write(16'h8010, 32'h1111);
    bus_write(16'h8020, 32'h2222);
    bus_write(16'h0008, 32'h0000_0055);
    wait_read(d);
    chk(d == {4'h0, 12'h055, reply(12'h055)}, "R6 read after writes", d, {4'h0, 12'h055, reply(12'h055)});
    wait_drain();

    // always-on clock
    bus_write(16'h0004, 32'h4000_0000);
    bus_read(16'h0004, d); chk(d == 32'h4000_0000, "R7 clk cfg readback", d, 32'h4000_0000);
    e0 = idle_edges; repeat (40) @(negedge clk);
    chk(idle_edges > e0, "R7 free-running sclk", idle_edges - e0, 1);
    bus_write(16'h8ABC, 32'h0000_5A5A);
    bus_write(16'h0008, 32'h0000_0ABC);
    wait_read(d);
    chk(d == {4'h0, 12'hABC, reply(12'hABC)}, "R7 read with clock on", d, {4'h0, 12'hABC, reply(12'hABC)});
    wait_drain();
    bus_write(16'h0004, 32'h0);
    repeat (10) @(negedge clk);
    e0 = idle_edges; repeat (40) @(negedge clk);
    chk(idle_edges == e0, "R7 gated again", idle_edges - e0, 0);

    // control and channel enables
    bus_write(16'h0000, 32'h1);
    bus_read(16'h0000, d); chk(d == 32'h1, "R8 ctrl readback", d, 1);
    bus_write(16'h0000, 32'h0);
    bus_read(16'h0000, d); chk(d == 32'h0, "R8 ctrl back to 12-bit", d, 0);
    bus_write(16'h0014, 32'hFFFF_FFFF);
    bus_read(16'h0014, d); chk(d == 32'hFFFF_FFFC, "R9 sw channels read zero", d, 32'hFFFF_FFFC);
    bus_write(16'h0018, 32'hFFFF_FFFF);
    bus_read(16'h0018, d); chk(d == 32'h0003_FFFF, "R9 upper enable width", d, 32'h0003_FFFF);
    chk(exp_q.size() == 0, "R1 scoreboard empty", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule